// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the serial front end of a small byte-organised non-volatile store. It sits as a slave on an SPI bus. It takes instructions MSB first on the data-in line and returns read data on the data-out line. Behind the serial logic is a small instruction engine that handles a write-enable latch, a status register, sequential reads, single-byte and paged writes, and a self-timed programming interval. The storage is a 512-byte internal register array that resets to the erased value 0xFF. A cycle counter of `PROG_CYCLES` system clocks stands in for the programming time.

The serial pins are oversampled by a system clock. Data is taken on rising serial clock edges and driven on falling edges, which suits both positive-clock SPI modes (idle low or idle high). The hold input freezes a transfer without ending it. The write-protect input and a two-bit protected-area field in the status register decide whether a programming request reaches the array. Page writes are buffered while they are shifted in. They are committed only when chip select is released on a whole-byte boundary.

Top module: `spiee_top`

## Requirements
- R1: While `csN` is high, `misoEn` is low and any partly received instruction is discarded; a rising `csN` ends the instruction, even if `holdN` is low at that moment.
- R2: Input bits are taken MSB first on rising `sclk` edges, and output bits change on falling `sclk` edges, MSB first.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it, both on the eighth bit. Opcode 0x05 returns the status byte {4'b0, protect[1:0], latch, busy} with busy at bit 0 and the latch at bit 1, and repeats it for every further byte.
- R4: Read opcode 0x03 carries address bit 8 in opcode bit 3 and is followed by address bits 7:0. Data bytes then follow from consecutive addresses, and 0x1FF is followed by 0x000.
- R5: Write opcode 0x02 uses the same address encoding as R4. Its data bytes reach the array only if the latch was set, at least one whole data byte arrived, and `csN` rises with no partial byte pending; otherwise nothing changes and no busy interval starts.
- R6: Within one write, successive bytes step only the low 4 address bits, so a 16-byte page wraps onto itself. Bytes outside that page are untouched.
- R7: An accepted write or status write sets the busy bit for exactly `PROG_CYCLES` clocks. When it ends, busy and the latch both clear. While busy, every opcode other than 0x05 is ignored and produces no output.
- R8: Opcode 0x01 followed by one data byte loads protect[1:0] from data bits 3:2, under the same latch and byte-boundary rules as R5, and starts a busy interval.
- R9: protect = 01 blocks writes to 0x180–0x1FF, 10 blocks 0x100–0x1FF, and 11 blocks the whole array. Blocked bytes keep their contents while unblocked bytes of the same write are stored.
- R10: If `wpN` is low when `csN` rises, writes and status writes are refused, no busy interval starts, and the latch is kept.
- R11: While `holdN` is low, `sclk` edges are ignored and `misoEn` is low. When `holdN` returns high, the transfer continues from the bit where it stopped.
- R12: After reset every array byte is 0xFF, the status byte is 0x00 and `misoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data in |
| holdN | input | 1 | Active-low transfer pause |
| wpN | input | 1 | Active-low write protect, sampled when chip select rises |
| miso | output | 1 | Serial data out |
| misoEn | output | 1 | Output enable for `miso` (low means high impedance) |

## Verification
The hold pause and the end of an instruction can happen in the same cycle: the bench shifts in a complete write, pulls `holdN` low, and raises `csN` while the hold is still in effect. The write is expected to be committed because the chip-select rise is judged on byte alignment alone. This is confirmed by the busy interval that follows and by reading the byte back afterwards. The bench also starts a hold in the middle of a read byte and sends `sclk` pulses and `mosi` changes during it. The byte received after release must still equal the stored value.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_AMASK = 8'hF7;  // clears the address-high bit

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRDATA, ST_SRDONE, ST_RDSR, ST_SKIP
  } ctrl_state_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadTxMem;
    logic loadTxSr;
    logic shiftTx;
    logic bufClear;
    logic bufWrite;
    logic commitPage;
    logic commitSr;
  } dp_strobe_t;
endpackage

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              holdN,
  input  logic              wpN,
  input  logic              busy,
  input  logic              wel,
  output dp_strobe_t        stb,
  output logic [ADDR_W-1:0] curAddr,
  output logic [7:0]        dataByte,
  output logic              txActive
);
  localparam int HI_W = ADDR_W - 8;

  ctrl_state_e       state;
  logic              sclkQ, csQ;
  logic [2:0]        bitCnt;
  logic [6:0]        shiftIn;
  logic [ADDR_W-1:0] addr;
  logic [HI_W-1:0]   hiBits;
  logic              isRead, gotData;
  logic [7:0]        srVal;
  logic              live, rise, fall, csRise, byteEnd;
  logic [7:0]        inByte;

  assign live    = !csN && holdN;
  assign rise    = live && sclk && !sclkQ;
  assign fall    = live && !sclk && sclkQ;
  assign csRise  = csN && !csQ;
  assign byteEnd = rise && (bitCnt == 3'd7);
  assign inByte  = {shiftIn, mosi};
  assign curAddr = (state == ST_ADDR) ? {hiBits, inByte} : addr;
  assign dataByte = (state == ST_SRDONE) ? srVal : inByte;
  assign txActive = live && (state == ST_RDATA || state == ST_RDSR);

  always_comb begin
    stb = '0;
    stb.shiftTx = fall;
    if (csRise && bitCnt == 3'd0 && wpN && wel) begin
      stb.commitPage = (state == ST_WDATA) && gotData;
      stb.commitSr   = (state == ST_SRDONE);
    end
    if (byteEnd) begin
      unique case (state)
        ST_OPC: if (!busy || inByte == OP_RDSR) begin
          stb.setWel   = (inByte == OP_WREN);
          stb.clrWel   = (inByte == OP_WRDI);
          stb.loadTxSr = (inByte == OP_RDSR);
        end
        ST_ADDR:  begin stb.loadTxMem = isRead; stb.bufClear = !isRead; end
        ST_RDATA: stb.loadTxMem = 1'b1;
        ST_WDATA: stb.bufWrite = 1'b1;
        ST_RDSR:  stb.loadTxSr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0; csQ <= 1'b1; state <= ST_OPC; bitCnt <= '0;
      shiftIn <= '0; addr <= '0; hiBits <= '0; isRead <= 1'b0;
      gotData <= 1'b0; srVal <= '0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
      if (csN) begin
        state <= ST_OPC; bitCnt <= '0; gotData <= 1'b0;
      end else if (rise) begin
        shiftIn <= inByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          unique case (state)
            ST_OPC: begin
              if (busy && inByte != OP_RDSR)            state <= ST_SKIP;
              else if (inByte == OP_RDSR)               state <= ST_RDSR;
              else if (inByte == OP_WRSR)               state <= ST_SRDATA;
              else if ((inByte & OP_AMASK) == OP_READ ||
                       (inByte & OP_AMASK) == OP_WRITE) begin
                state  <= ST_ADDR;
                isRead <= ((inByte & OP_AMASK) == OP_READ);
                hiBits <= inByte[3 +: HI_W];
              end else                                  state <= ST_SKIP;
            end
            ST_ADDR: begin
              addr  <= isRead ? curAddr + ADDR_W'(1) : curAddr;
              state <= isRead ? ST_RDATA : ST_WDATA;
            end
            ST_RDATA: addr <= addr + ADDR_W'(1);
            ST_WDATA: begin
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
              gotData <= 1'b1;
            end
            ST_SRDATA: begin srVal <= inByte; state <= ST_SRDONE; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spiee_dp.sv
module spiee_dp
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dp_strobe_t                   stb,
  input  logic [$clog2(MEM_BYTES)-1:0] addr,
  input  logic [7:0]                   dataByte,
  output logic                         miso,
  output logic                         wip,
  output logic                         wel
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic [7:0]               mem     [MEM_BYTES];
  logic [7:0]               pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    valid;
  logic [ADDR_W-PAGE_W-1:0] page;
  logic [1:0]               bp;
  logic [7:0]               txByte;
  logic [CNT_W-1:0]         progCnt;
  logic [7:0]               status;

  assign status = {4'b0000, bp, wel, wip};

  function automatic logic isProt(input logic [ADDR_W-1:0] a, input logic [1:0] sel);
    logic [1:0] q;
    q = a[ADDR_W-1 -: 2];
    unique case (sel)
      2'b00:   return 1'b0;
      2'b01:   return q == 2'b11;
      2'b10:   return q[1];
      default: return 1'b1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
      valid <= '0; page <= '0; bp <= '0; txByte <= '0; miso <= 1'b0;
      wip <= 1'b0; wel <= 1'b0; progCnt <= '0;
    end else begin
      if (stb.loadTxMem)     txByte <= mem[addr];
      else if (stb.loadTxSr) txByte <= status;
      else if (stb.shiftTx) begin
        miso   <= txByte[7];
        txByte <= {txByte[6:0], 1'b0};
      end
      if (stb.setWel) wel <= 1'b1;
      if (stb.clrWel) wel <= 1'b0;
      if (stb.bufClear) valid <= '0;
      if (stb.bufWrite) begin
        pageBuf[addr[PAGE_W-1:0]] <= dataByte;
        valid[addr[PAGE_W-1:0]]   <= 1'b1;
        page <= addr[ADDR_W-1:PAGE_W];
      end
      if (stb.commitPage && !wip) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (valid[i] && !isProt({page, i[PAGE_W-1:0]}, bp))
            mem[{page, i[PAGE_W-1:0]}] <= pageBuf[i];
        wip <= 1'b1; progCnt <= '0;
      end
      if (stb.commitSr && !wip) begin
        bp <= dataByte[3:2];
        wip <= 1'b1; progCnt <= '0;
      end
      if (wip) begin
        progCnt <= progCnt + CNT_W'(1);
        if (progCnt == CNT_W'(PROG_CYCLES - 1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spiee_top.sv
module spiee_top
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  input  logic holdN,
  input  logic wpN,
  output logic miso,
  output logic misoEn
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  dp_strobe_t        stb;
  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        dataByte;
  logic              wip, wel;

  spiee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .holdN(holdN), .wpN(wpN), .busy(wip), .wel(wel), .stb(stb),
    .curAddr(curAddr), .dataByte(dataByte), .txActive(misoEn)
  );

  spiee_dp #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
             .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(curAddr),
    .dataByte(dataByte), .miso(miso), .wip(wip), .wel(wel)
  );
endmodule

// File: rtl/spiee_chk.sv
module spiee_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic holdN,
  input logic wpN,
  input logic misoEn,
  input logic wip,
  input logic wel
);
  int busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)    busyCnt <= 0;
    else if (wip) busyCnt <= busyCnt + 1;
    else          busyCnt <= 0;
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !misoEn);                                   // R1
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> !misoEn);                                // R11
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> busyCnt == PROG_CYCLES);             // R7
  AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);                               // R7
  AST_PROTECT_PIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wpN));                         // R10
  AST_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel));                         // R5
endmodule

bind spiee_top spiee_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .holdN(holdN), .wpN(wpN),
  .misoEn(misoEn), .wip(wip), .wel(wel)
);

// File: tb/test_spiee_top.sv
`timescale 1ns/1ps
module test_spiee_top;
  localparam int PROG = 400;
  localparam logic [7:0] C_WREN = 8'h06, C_WRDI = 8'h04, C_RDSR = 8'h05;
  localparam logic [7:0] C_WRSR = 8'h01, C_READ = 8'h03, C_WRITE = 8'h02;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic holdN = 1'b1, wpN = 1'b1;
  logic miso, misoEn;

  spiee_top #(.PROG_CYCLES(PROG)) i_spiee_top (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .holdN(holdN), .wpN(wpN), .miso(miso), .misoEn(misoEn)
  );

  always #4 clk = ~clk;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t       expQ[$];
  event       rxEvt;
  logic [7:0] rxVal;
  int         nChecks = 0, nErrors = 0;
  logic [7:0] model [512];
  logic [1:0] mBp = 2'b00;
  logic [7:0] wdat [20];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the expected byte for every captured byte
  initial forever begin
    @(rxEvt);
    if (expQ.size() == 0) begin
      nChecks++; nErrors++;
      $display("FAIL R2 actual %h expected none", rxVal);
    end else begin
      exp_t it;
      it = expQ.pop_front();
      chk(rxVal, it.val, it.req);
    end
  end

  task automatic holdPause();
    @(negedge clk) holdN = 1'b0;
    repeat (3) @(negedge clk);
    chk({7'b0, misoEn}, 8'h00, "R11 misoEn during hold");
    for (int k = 0; k < 3; k++) begin
      mosi = ~mosi; sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; repeat (2) @(negedge clk);
    end
    holdN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic spiByte(input logic [7:0] tx, input int nbits, input bit grab, input int holdAt);
    logic [7:0] rx;
    rx = '0;
    for (int b = 7; b >= 8 - nbits; b--) begin
      @(negedge clk) mosi = tx[b];
      repeat (3) @(negedge clk);
      rx[b] = miso; sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (b == holdAt) holdPause();
    end
    if (grab) begin rxVal = rx; ->rxEvt; end
  endtask

  task automatic sel();   @(negedge clk) csN = 1'b0; repeat (2) @(negedge clk); endtask
  task automatic desel(); @(negedge clk) csN = 1'b1; repeat (4) @(negedge clk); endtask
  task automatic cmd(input logic [7:0] op); sel(); spiByte(op, 8, 0, -1); desel(); endtask
  task automatic waitBusy(); repeat (PROG + 50) @(negedge clk); endtask

  function automatic logic [7:0] withHi(input logic [7:0] op, input logic [8:0] a);
    return op | {4'b0, a[8], 3'b000};
  endfunction

  task automatic rdsr(input logic [7:0] exp, input string req);
    sel(); spiByte(C_RDSR, 8, 0, -1);
    expQ.push_back('{exp, req}); spiByte(8'h00, 8, 1, -1);
    desel();
  endtask

  task automatic readExp(input logic [8:0] a, input int n, input string req);
    sel(); spiByte(withHi(C_READ, a), 8, 0, -1); spiByte(a[7:0], 8, 0, -1);
    for (int i = 0; i < n; i++) begin
      expQ.push_back('{model[9'(a + 9'(i))], req});
      spiByte(8'h00, 8, 1, -1);
    end
    desel();
  endtask

  function automatic logic benchProt(input logic [8:0] a);
    case (mBp)
      2'b00: return 1'b0;
      2'b01: return a >= 9'h180;
      2'b10: return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic modelPage(input logic [8:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      logic [8:0] t;
      t = a; t[3:0] = a[3:0] + 4'(k);
      if (!benchProt(t)) model[t] = wdat[k];
    end
  endtask

  task automatic writeRaw(input logic [8:0] a, input int n);
    sel(); spiByte(withHi(C_WRITE, a), 8, 0, -1); spiByte(a[7:0], 8, 0, -1);
    for (int i = 0; i < n; i++) spiByte(wdat[i], 8, 0, -1);
    desel();
  endtask

  task automatic goodWrite(input logic [8:0] a, input int n);
    cmd(C_WREN); writeRaw(a, n); modelPage(a, n); waitBusy();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cmd(C_WREN); sel(); spiByte(C_WRSR, 8, 0, -1); spiByte(v, 8, 0, -1); desel();
    mBp = v[3:2]; waitBusy();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk({7'b0, misoEn}, 8'h00, "R12 misoEn after reset");
    rdsr(8'h00, "R12 status after reset");
    readExp(9'h000, 2, "R12 erased array");

    // R3 latch set and clear
    cmd(C_WREN); rdsr(8'h02, "R3 latch after 0x06");
    rdsr(8'h02, "R3 status repeat");
    cmd(C_WRDI); rdsr(8'h00, "R3 latch after 0x04");

    // R5 write without latch is dropped
    wdat[0] = 8'h5A; writeRaw(9'h005, 1);
    rdsr(8'h00, "R5 no busy without latch");
    readExp(9'h005, 1, "R5 unlatched write ignored");

    // R5 R7 accepted two-byte write, busy window
    wdat[0] = 8'hA5; wdat[1] = 8'h3C;
    cmd(C_WREN); writeRaw(9'h005, 2); modelPage(9'h005, 2);
    rdsr(8'h03, "R7 busy with latch during programming");
    sel(); spiByte(C_READ, 8, 0, -1); spiByte(8'h05, 8, 0, -1);
    chk({7'b0, misoEn}, 8'h00, "R7 read ignored while busy");
    spiByte(8'h00, 8, 0, -1);
    chk({7'b0, misoEn}, 8'h00, "R7 read ignored while busy data");
    desel();
    waitBusy();
    rdsr(8'h00, "R7 busy and latch cleared");
    readExp(9'h005, 2, "R5 R4 written bytes");

    // R5 partial byte aborts the write
    cmd(C_WREN);
    sel(); spiByte(C_WRITE, 8, 0, -1); spiByte(8'h10, 8, 0, -1);
    spiByte(8'hC3, 8, 0, -1); spiByte(8'hFF, 3, 0, -1); desel();
    rdsr(8'h02, "R5 partial byte no commit");
    readExp(9'h010, 1, "R5 partial byte array unchanged");
    cmd(C_WRDI);

    // R6 page wrap
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
    goodWrite(9'h10E, 4);
    readExp(9'h10E, 3, "R6 page tail and next page untouched");
    readExp(9'h100, 3, "R6 wrapped bytes at page start");

    // R4 read wraps over the top
    wdat[0] = 8'h77; goodWrite(9'h1FF, 1);
    wdat[0] = 8'h99; goodWrite(9'h000, 1);
    readExp(9'h1FE, 3, "R4 address wrap");

    // R10 write protect pin
    wpN = 1'b0;
    cmd(C_WREN); wdat[0] = 8'h12; writeRaw(9'h020, 1);
    rdsr(8'h02, "R10 write refused latch kept");
    sel(); spiByte(C_WRSR, 8, 0, -1); spiByte(8'h0C, 8, 0, -1); desel();
    rdsr(8'h02, "R10 status write refused");
    readExp(9'h020, 1, "R10 array unchanged");
    wpN = 1'b1;
    cmd(C_WRDI);

    // R8 R9 protected areas
    wrsr(8'h04); rdsr(8'h04, "R8 protect field 01");
    wdat[0] = 8'h55; goodWrite(9'h17F, 1);
    wdat[0] = 8'h66; cmd(C_WREN); writeRaw(9'h180, 1); waitBusy();
    readExp(9'h17F, 2, "R9 upper quarter blocked");
    wrsr(8'h08); rdsr(8'h08, "R8 protect field 10");
    wdat[0] = 8'h01; cmd(C_WREN); writeRaw(9'h100, 1); waitBusy();
    wdat[0] = 8'h02; goodWrite(9'h0FF, 1);
    readExp(9'h0FF, 2, "R9 upper half blocked");
    wrsr(8'h0C);
    wdat[0] = 8'hEE; cmd(C_WREN); writeRaw(9'h000, 1); waitBusy();
    readExp(9'h000, 1, "R9 whole array blocked");
    wrsr(8'h00); rdsr(8'h00, "R8 protect cleared");

    // R11 hold inside a read byte
    sel(); spiByte(C_READ, 8, 0, -1); spiByte(8'h05, 8, 0, -1);
    expQ.push_back('{model[9'h005], "R11 byte after hold"});
    spiByte(8'h00, 8, 1, 4);
    desel();

    // R1 R11 chip select rises while held: write still committed
    cmd(C_WREN);
    sel(); spiByte(C_WRITE, 8, 0, -1); spiByte(8'h30, 8, 0, -1); spiByte(8'h42, 8, 0, -1);
    @(negedge clk) holdN = 1'b0;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
    chk({7'b0, misoEn}, 8'h00, "R1 deselected output off");
    holdN = 1'b1;
    repeat (2) @(negedge clk);
    rdsr(8'h03, "R1 write committed under hold");
    wdat[0] = 8'h42; modelPage(9'h030, 1); waitBusy();
    readExp(9'h030, 1, "R1 R2 byte committed under hold");

    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule